// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the device side of a word-wide parallel NOR flash, seen from a synchronous host bus. The host drives active-low chip-enable, write-enable and output-enable along with an address and a 16-bit data word. Each write strobe is one bus cycle. A state machine counts these cycles against a protection unlock sequence. A finished sequence starts one of four internal operations: word program, sector erase, block erase or chip erase. Each operation holds the device busy for a set number of clock cycles. The result reaches a small internal array when the busy period ends.

While an operation runs, every write is dropped and reads return a status word instead of array data. That status word carries a data-polling bit and a toggle bit. Erase sets words to all ones. Program can only clear bits. The array models a window of `2**MEM_AW` words at the bottom of the address space, and sector and block boundaries come from parameters.

The decoder states are IDLE, UNLK1, UNLK2, PGM_ARMED, ERS_SETUP, ERS_UNLK1 and ERS_ARMED. They have these transitions:
- IDLE to UNLK1 on AAh at 5555h.
- UNLK1 to UNLK2 on 55h at 2AAAh.
- UNLK2 to PGM_ARMED on A0h at 5555h.
- UNLK2 to ERS_SETUP on 80h at 5555h.
- ERS_SETUP to ERS_UNLK1 on AAh at 5555h.
- ERS_UNLK1 to ERS_ARMED on 55h at 2AAAh.
- PGM_ARMED to IDLE on any write, which launches a program.
- ERS_ARMED to IDLE on any write, which launches an erase if the code matches.
- Any other write returns the machine to IDLE.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset every array word reads FFFFh, busy is low, and the decoder is in IDLE.
- R2: rdata_oe is high only while ce_n and oe_n are both low. Otherwise rdata_oe is low and rdata is 0.
- R3: A write cycle spans the cycles in which ce_n and we_n are both low. The address is taken in the first cycle of the span. The data is taken in the first cycle in which the span has ended, and the decoder acts at that point.
- R4: The unlock path follows the state list above. Only wdata[7:0] is compared. Any write that does not match the expected cycle sends the decoder to IDLE without starting an operation.
- R5: A program write (the fourth cycle, in PGM_ARMED) sets the addressed word to its old value ANDed with the data, so a bit never goes from 0 to 1.
- R6: Final code 30h starts a sector erase. Every word whose address shifted right by SECT_SHIFT equals the final address shifted the same way becomes FFFFh. All other words are unchanged.
- R7: Final code 50h starts a block erase. It works as R6 but uses BLK_SHIFT.
- R8: Final code 10h at address 5555h erases the whole array. Code 10h at any other address starts nothing.
- R9: busy rises on the second clock edge after the edge that completes the final cycle. It stays high for PGM_CYC cycles for a program, ERS_CYC for a sector or block erase, and CHIP_CYC for a chip erase. The array changes at the edge where busy falls.
- R10: While busy, writes have no effect on the decoder or the array.
- R11: A read while busy returns a status word. Bit 7 is the complement of bit 7 of the program data, or 0 during an erase. Bit 6 inverts at the start of each read access. All other bits are 0.
- R12: Addresses with any bit at or above MEM_AW set read as FFFFh, and programming them leaves the array unchanged. They still produce a full busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status word |
| rdata_oe | output | 1 | Drive enable for rdata |
| busy | output | 1 | An internal operation is running |

## Verification
The bench builds the block with MEM_AW=6, SECT_SHIFT=2, BLK_SHIFT=4, PGM_CYC=5, ERS_CYC=7 and CHIP_CYC=9. With these values the 64-word window holds sixteen sectors and four blocks. Sector and block erases therefore hit a real subset of the array, and their edges are visible by reading back the whole window. The short busy periods let one run measure every busy length, poll status several times within one operation, and place writes inside a busy period. The random operations that follow still finish well inside the run limit.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PGM,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } nor_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PGM_ARMED,
        S_ERS_SETUP,
        S_ERS_UNLK1,
        S_ERS_ARMED
    } dec_state_e;

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] CODE_PGM  = 8'hA0;
    localparam logic [7:0] CODE_ERS  = 8'h80;
    localparam logic [7:0] CODE_SECT = 8'h30;
    localparam logic [7:0] CODE_BLK  = 8'h50;
    localparam logic [7:0] CODE_CHIP = 8'h10;

endpackage

// File: rtl/nor_seq_decoder.sv
module nor_seq_decoder
    import nor_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              busy_i,
    output logic              go_o,
    output nor_op_e           op_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [15:0]       op_data_o
);

    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(16'h5555);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(16'h2AAA);

    dec_state_e        state, state_nx;
    nor_op_e           launch;
    logic              wr_on, wr_q, wr_end, step;
    logic [ADDR_W-1:0] cyc_addr;
    logic [7:0]        lo;
    logic              at_a, at_b;

    assign wr_on  = !ce_n && !we_n;
    assign wr_end = wr_q && !wr_on;
    assign step   = wr_end && !busy_i && !go_o;
    assign lo     = wdata[7:0];
    assign at_a   = (cyc_addr == ADR_A);
    assign at_b   = (cyc_addr == ADR_B);

    // cycle tracking: address at strobe start (R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            cyc_addr <= '0;
        end else begin
            wr_q <= wr_on;
            if (wr_on && !wr_q) cyc_addr <= addr;
        end
    end

    // next state and launch decode
    always_comb begin
        state_nx = state;
        launch   = OP_NONE;
        if (step) begin
            state_nx = S_IDLE;
            unique case (state)
                S_IDLE:      if (lo == KEY_A && at_a) state_nx = S_UNLK1;
                S_UNLK1:     if (lo == KEY_B && at_b) state_nx = S_UNLK2;
                S_UNLK2: begin
                    if (lo == CODE_PGM && at_a)      state_nx = S_PGM_ARMED;
                    else if (lo == CODE_ERS && at_a) state_nx = S_ERS_SETUP;
                end
                S_PGM_ARMED: launch = OP_PGM;
                S_ERS_SETUP: if (lo == KEY_A && at_a) state_nx = S_ERS_UNLK1;
                S_ERS_UNLK1: if (lo == KEY_B && at_b) state_nx = S_ERS_ARMED;
                S_ERS_ARMED: begin
                    if (lo == CODE_SECT)             launch = OP_SECT;
                    else if (lo == CODE_BLK)         launch = OP_BLK;
                    else if (lo == CODE_CHIP && at_a) launch = OP_CHIP;
                end
                default:     state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // launch outputs, held until the next launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_o      <= 1'b0;
            op_o      <= OP_NONE;
            op_addr_o <= '0;
            op_data_o <= '0;
        end else begin
            go_o <= (launch != OP_NONE);
            if (launch != OP_NONE) begin
                op_o      <= launch;
                op_addr_o <= cyc_addr;
                op_data_o <= wdata;
            end
        end
    end

    // R10
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (state == S_IDLE));

    // R10
    no_launch_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !busy_i);

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
    import nor_pkg::*;
#(
    parameter int PGM_CYC  = 5,
    parameter int ERS_CYC  = 7,
    parameter int CHIP_CYC = 9
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go_i,
    input  nor_op_e op_i,
    output logic    busy_o,
    output logic    done_o
);

    localparam int MAXC = (PGM_CYC > ERS_CYC)
                        ? ((PGM_CYC > CHIP_CYC) ? PGM_CYC : CHIP_CYC)
                        : ((ERS_CYC > CHIP_CYC) ? ERS_CYC : CHIP_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (go_i) begin
            unique case (op_i)
                OP_PGM:  cnt <= CW'(PGM_CYC);
                OP_CHIP: cnt <= CW'(CHIP_CYC);
                OP_SECT,
                OP_BLK:  cnt <= CW'(ERS_CYC);
                default: cnt <= '0;
            endcase
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);
    assign done_o = (cnt == CW'(1));

    // R9
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXC));

endmodule

// File: rtl/nor_array.sv
module nor_array
    import nor_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MEM_AW     = 6,
    parameter int SECT_SHIFT = 11,
    parameter int BLK_SHIFT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply_i,
    input  nor_op_e           op_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [15:0]       op_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_word_o
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [15:0]       mem [DEPTH];
    logic [MEM_AW-1:0] pidx;
    logic              p_in_win, r_in_win;
    logic [15:0]       old_word;

    assign pidx      = op_addr_i[MEM_AW-1:0];
    assign p_in_win  = (op_addr_i[ADDR_W-1:MEM_AW] == '0);
    assign r_in_win  = (rd_addr_i[ADDR_W-1:MEM_AW] == '0);
    assign old_word  = mem[pidx];
    assign rd_word_o = r_in_win ? mem[rd_addr_i[MEM_AW-1:0]] : 16'hFFFF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
        end else if (apply_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                unique case (op_i)
                    OP_PGM:
                        if (p_in_win && MEM_AW'(i) == pidx) mem[i] <= mem[i] & op_data_i;
                    OP_SECT:
                        if ((ADDR_W'(i) >> SECT_SHIFT) == (op_addr_i >> SECT_SHIFT))
                            mem[i] <= 16'hFFFF;
                    OP_BLK:
                        if ((ADDR_W'(i) >> BLK_SHIFT) == (op_addr_i >> BLK_SHIFT))
                            mem[i] <= 16'hFFFF;
                    OP_CHIP: mem[i] <= 16'hFFFF;
                    default: ;
                endcase
            end
        end
    end

    // R5
    pgm_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_i == OP_PGM) |=> ((old_word & ~$past(old_word)) == 16'h0000));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MEM_AW     = 6,
    parameter int SECT_SHIFT = 11,
    parameter int BLK_SHIFT  = 15,
    parameter int PGM_CYC    = 5,
    parameter int ERS_CYC    = 7,
    parameter int CHIP_CYC   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rdata_oe,
    output logic              busy
);

    logic              go, done, rd_on, rd_q, tog, dpoll;
    nor_op_e           op;
    logic [ADDR_W-1:0] op_addr;
    logic [15:0]       op_data, rd_word, status;

    nor_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk, .rst_n, .ce_n, .we_n, .addr, .wdata,
        .busy_i(busy), .go_o(go), .op_o(op),
        .op_addr_o(op_addr), .op_data_o(op_data)
    );

    nor_busy_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .CHIP_CYC(CHIP_CYC)) u_tmr (
        .clk, .rst_n, .go_i(go), .op_i(op), .busy_o(busy), .done_o(done)
    );

    nor_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW),
                .SECT_SHIFT(SECT_SHIFT), .BLK_SHIFT(BLK_SHIFT)) u_arr (
        .clk, .rst_n, .apply_i(done), .op_i(op), .op_addr_i(op_addr),
        .op_data_i(op_data), .rd_addr_i(addr), .rd_word_o(rd_word)
    );

    assign rd_on = !ce_n && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_on;
            if (rd_on && !rd_q && busy) tog <= ~tog;
        end
    end

    always_comb begin
        dpoll    = (op == OP_PGM) ? ~op_data[7] : 1'b0;
        status   = {8'h00, dpoll, tog, 6'b000000};
        rdata_oe = rd_on;
        rdata    = !rd_on ? 16'h0000 : (busy ? status : rd_word);
    end

    // R11
    status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_on) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'b000000));

    // R2
    released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == 16'h0000));

endmodule

// File: tb/tb_nor_cmd_ctrl.sv
module tb_nor_cmd_ctrl;

    localparam int AW = 16, MAW = 6, SS = 2, BS = 4;
    localparam int PC = 5, EC = 7, CC = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic rdata_oe, busy;

    int checks = 0, errors = 0;
    logic [15:0] model [64];
    bit finished = 0;

    nor_cmd_ctrl #(.ADDR_W(AW), .MEM_AW(MAW), .SECT_SHIFT(SS), .BLK_SHIFT(BS),
                   .PGM_CYC(PC), .ERS_CYC(EC), .CHIP_CYC(CC)) dut (
        .clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .wdata, .rdata, .rdata_oe, .busy
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); addr = a;  wdata = ~d; ce_n = 0; we_n = 0;
        @(negedge clk); addr = ~a; wdata = d;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; addr = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk); v = rdata;
        chk(rdata_oe === 1'b1, "R2 oe during read", rdata_oe, 1);
        oe_n = 1; ce_n = 1;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (busy) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic seq_pgm(input logic [15:0] a, input logic [15:0] d);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(a, d);
    endtask

    task automatic seq_ers(input logic [15:0] a, input logic [7:0] code);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, {8'h00, code});
    endtask

    function automatic void m_pgm(input logic [15:0] a, input logic [15:0] d);
        if (a[15:6] == '0) model[a[5:0]] = model[a[5:0]] & d;
    endfunction

    function automatic void m_ers(input logic [15:0] a, input int shift);
        for (int i = 0; i < 64; i++)
            if ((i >> shift) == (int'(a) >> shift)) model[i] = 16'hFFFF;
    endfunction

    task automatic cmp_all(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 64; i++) begin
            rd(16'(i), v);
            chk(v == model[i], tag, v, model[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy after reset", busy, 0);
        cmp_all("R1 erased at reset");
        // R2 gating
        ce_n = 0; oe_n = 1; #1;
        chk(rdata_oe == 0 && rdata == 0, "R2 oe_n high", rdata, 0);
        ce_n = 1; oe_n = 0; #1;
        chk(rdata_oe == 0 && rdata == 0, "R2 ce_n high", rdata, 0);
        oe_n = 1;
        // R5 R11 R3 program with status polling
        seq_pgm(16'h0005, 16'h1234); m_pgm(16'h0005, 16'h1234);
        rd(16'h0005, v); rd(16'h0005, v2);
        chk(v[7] == 1'b1, "R11 data poll bit", v[7], 1);
        chk(v[15:8] == 0 && v[5:0] == 0, "R11 status other bits", v, 0);
        chk(v[6] != v2[6], "R11 toggle bit", v2[6], !v[6]);
        wait_busy(n);
        seq_pgm(16'h0005, 16'h00FF); m_pgm(16'h0005, 16'h00FF);
        wait_busy(n);
        chk(n == PC, "R9 program busy length", n, PC);
        rd(16'h0005, v);
        chk(v == 16'h0034, "R5 AND program", v, 16'h0034);
        // R11 erase-style poll bit with data bit7 set
        seq_pgm(16'h0009, 16'h0080); m_pgm(16'h0009, 16'h0080);
        rd(16'h0009, v);
        chk(v[7] == 1'b0, "R11 poll bit complement", v[7], 0);
        wait_busy(n);
        for (int i = 0; i < 12; i++) begin
            seq_pgm(16'(i), 16'h0F0F ^ 16'(i)); m_pgm(16'(i), 16'h0F0F ^ 16'(i)); wait_busy(n);
        end
        // R6 sector erase
        seq_ers(16'h0005, 8'h30); m_ers(16'h0005, SS);
        rd(16'h0005, v);
        chk(v[7] == 1'b0, "R11 erase poll bit", v[7], 0);
        wait_busy(n);
        cmp_all("R6 sector erase");
        seq_ers(16'h0002, 8'h30); m_ers(16'h0002, SS);
        wait_busy(n);
        chk(n == EC, "R9 sector busy length", n, EC);
        // R7 block erase
        for (int i = 14; i < 40; i += 3) begin
            seq_pgm(16'(i), 16'h1111); m_pgm(16'(i), 16'h1111); wait_busy(n);
        end
        seq_ers(16'h0013, 8'h50); m_ers(16'h0013, BS);
        wait_busy(n);
        chk(n == EC, "R9 block busy length", n, EC);
        cmp_all("R7 block erase");
        // R8 chip erase at wrong address then right address
        seq_ers(16'h0013, 8'h10);
        wait_busy(n);
        chk(n == 0, "R8 chip code at wrong address", n, 0);
        cmp_all("R8 no change");
        seq_ers(16'h5555, 8'h10);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        // R10 write during busy ignored
        wr(16'h5555, 16'h00AA);
        wait_busy(n);
        chk(n > 0, "R10 busy spans write", n, 1);
        wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'h0002, 16'h0000);
        wait_busy(n);
        chk(n == 0, "R10 no launch after ignored write", n, 0);
        cmp_all("R8 chip erase");
        // R4 mismatch sequence
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0056); wr(16'h5555, 16'h00A0); wr(16'h0003, 16'h0000);
        wait_busy(n);
        chk(n == 0, "R4 bad unlock no op", n, 0);
        rd(16'h0003, v);
        chk(v == 16'hFFFF, "R4 word untouched", v, 16'hFFFF);
        // R4 high byte ignored
        wr(16'h5555, 16'h12AA); wr(16'h2AAA, 16'h3455); wr(16'h5555, 16'h56A0); wr(16'h0003, 16'h00F0);
        m_pgm(16'h0003, 16'h00F0);
        wait_busy(n);
        chk(n == PC, "R4 high byte ignored", n, PC);
        rd(16'h0003, v);
        chk(v == 16'h00F0, "R4 program done", v, 16'h00F0);
        // R3 address at start: wr drives ~a late, so a stray word must stay intact
        rd(16'hFFFC, v);
        chk(v == 16'hFFFF, "R3 R12 out-of-window read", v, 16'hFFFF);
        // R12 out-of-window program
        seq_pgm(16'h0100, 16'h0000);
        wait_busy(n);
        chk(n == PC, "R12 busy still runs", n, PC);
        cmp_all("R12 array unchanged");
        // random mix
        for (int it = 0; it < 40; it++) begin
            int sel = $urandom_range(0, 5);
            logic [15:0] a = 16'($urandom_range(0, 63));
            logic [15:0] d = 16'($urandom);
            if (sel < 4) begin
                seq_pgm(a, d); m_pgm(a, d); wait_busy(n);
                chk(n == PC, "R9 R5 random program length", n, PC);
            end else if (sel == 4) begin
                seq_ers(a, 8'h30); m_ers(a, SS); wait_busy(n);
                chk(n == EC, "R6 random sector length", n, EC);
            end else begin
                seq_ers(a, 8'h50); m_ers(a, BS); wait_busy(n);
                chk(n == EC, "R7 random block length", n, EC);
            end
            for (int k = 0; k < 4; k++) begin
                logic [15:0] ra = 16'($urandom_range(0, 63));
                rd(ra, v);
                chk(v == model[ra[5:0]], "R5 R6 R7 random readback", v, model[ra[5:0]]);
            end
        end
        cmp_all("R5 final readback");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule